// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides whether each write-type command sent to a serial NOR flash can run. It holds a small status register: a write-enable latch, a three-bit block-protect field and a sticky status-lock bit. It takes decoded command strobes from an upstream SPI decoder, together with the target byte address, the level of the write-protect pin and a busy flag that stands for a program or erase still in progress.

For every strobe it handles, the block produces a one-cycle accept or reject pulse on the cycle after the strobe, and it updates the register. The block-protect field selects a group of sectors at the top of the array. Program and erase commands that target that group are refused. When the lock bit is set and the write-protect pin is low, the block is in hardware-protected mode and the status register cannot be changed. The SPI shifter, the memory array and the operation timing lie outside this block.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset, `statusOut` is 0, `accept` and `reject` are low, and `hwMode` is 0 while `wpLevel` is high.
- R2: When not busy, a write-enable strobe is accepted and sets the latch (`statusOut[1]`). A write-disable strobe is accepted and clears it.
- R3: While the lock bit is 0 and the latch is set, a status write is accepted whatever the level of `wpLevel`. It loads the lock bit (`statusOut[7]`) from `srData[7]` and the protect field (`statusOut[4:2]`) from `srData[4:2]`.
- R4: A status write, page program, sector erase or bulk erase is rejected if the latch is clear. A rejected command leaves the lock bit and the protect field unchanged.
- R5: While the lock bit is 1 and `wpLevel` is low, `hwMode` is 1 and every status write is rejected, even with the latch set.
- R6: Hardware-protected mode is reached either by setting the lock bit while `wpLevel` is low, or by driving `wpLevel` low after the bit is set. It is left only by driving `wpLevel` high, after which status writes are accepted again.
- R7: The sector index is `addr[21:16]` (64 sectors of 64 KB). A protect value n from 1 to 6 guards the top 2^(n-1) sectors, and the value 7 guards all 64. A page program or sector erase to a guarded sector is rejected, and one to any other sector is accepted when the latch is set.
- R8: A bulk erase is rejected whenever the protect field is nonzero, and accepted when it is zero and the latch is set.
- R9: The latch is clear after any status write, page program, sector erase or bulk erase, whether accepted or rejected.
- R10: While `busy` is high, every strobe is ignored: no pulse is produced and bits 7..1 of `statusOut` do not change. `statusOut[0]` mirrors `busy`.
- R11: Each strobe handled while not busy gives exactly one pulse, on `accept` or on `reject`, one cycle wide, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWren | input | 1 | Write-enable strobe |
| cmdWrdi | input | 1 | Write-disable strobe |
| cmdWrsr | input | 1 | Status write strobe |
| cmdProg | input | 1 | Page program strobe |
| cmdSecErase | input | 1 | Sector erase strobe |
| cmdBulkErase | input | 1 | Bulk erase strobe |
| addr | input | 22 | Target byte address |
| srData | input | 8 | Value offered by a status write |
| wpLevel | input | 1 | Write-protect pin level (1 = high) |
| busy | input | 1 | Operation in progress |
| accept | output | 1 | Command accepted pulse |
| reject | output | 1 | Command rejected pulse |
| hwMode | output | 1 | 1 = hardware-protected, 0 = software-protected |
| statusOut | output | 8 | Status register: lock, 0, 0, protect[2:0], latch, busy |

## Verification
The assertions assume that at most one command strobe is high in any cycle, since the upstream decoder produces one command at a time. The checker tests this assumption itself. The bench drives each strobe for exactly one cycle, away from the clock edge, and never overlaps two strobes. The bench changes `wpLevel` and `busy` only between commands, so every rule is evaluated against a stable pin level and a stable busy state.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  // Bit positions inside the status register image.
  localparam int LOCK_BIT = 7;
  localparam int BP_HI    = 4;
  localparam int BP_LO    = 2;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
  localparam int BP_W     = BP_HI - BP_LO + 1;

  // Register update strobes passed from control to the datapath.
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
  } wpgStrobe_t;
endpackage

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int SECTOR_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpgStrobe_t        strobe,
  input  logic [7:0]        srData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wpLevel,
  input  logic              busy,
  output logic              wel,
  output logic              hwLock,
  output logic              addrProt,
  output logic              bpAny,
  output logic [7:0]        statusOut
);
  localparam int SEC_LSB = ADDR_W - SECTOR_BITS;
  localparam int SPAN_W  = SECTOR_BITS + 2;
  localparam logic [SPAN_W-1:0] NSEC = SPAN_W'(1) << SECTOR_BITS;

  logic            lockBit;
  logic [BP_W-1:0] bpField;
  logic            welQ;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] secIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit <= 1'b0;
      bpField <= '0;
      welQ    <= 1'b0;
    end else begin
      if (strobe.loadSr) begin
        lockBit <= srData[LOCK_BIT];
        bpField <= srData[BP_HI:BP_LO];
      end
      if (strobe.setWel)      welQ <= 1'b1;
      else if (strobe.clrWel) welQ <= 1'b0;
    end
  end

  // Number of guarded sectors at the top of the array.
  always_comb begin
    if (bpField == '0)
      span = '0;
    else if (int'(bpField) - 1 >= SECTOR_BITS)
      span = NSEC;
    else
      span = SPAN_W'(1) << (bpField - BP_W'(1));
  end

  assign secIdx    = SPAN_W'(addr[ADDR_W-1:SEC_LSB]);
  assign addrProt  = (secIdx + span) >= NSEC;
  assign bpAny     = |bpField;
  assign wel       = welQ;
  assign hwLock    = lockBit & ~wpLevel;
  assign statusOut = {lockBit, 2'b00, bpField, welQ, busy};
endmodule

// File: rtl/wpg_control.sv
module wpg_control
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdWrsr,
  input  logic       cmdProg,
  input  logic       cmdSecErase,
  input  logic       cmdBulkErase,
  input  logic       busy,
  input  logic       wel,
  input  logic       hwLock,
  input  logic       addrProt,
  input  logic       bpAny,
  output wpgStrobe_t strobe,
  output logic       accept,
  output logic       reject
);
  logic anyCmd;
  logic live;
  logic okNow;

  assign anyCmd = cmdWren | cmdWrdi | cmdWrsr | cmdProg | cmdSecErase | cmdBulkErase;
  assign live   = anyCmd & ~busy;

  always_comb begin
    okNow = 1'b0;
    if (cmdWren || cmdWrdi)            okNow = 1'b1;
    else if (cmdWrsr)                  okNow = wel & ~hwLock;
    else if (cmdProg || cmdSecErase)   okNow = wel & ~addrProt;
    else if (cmdBulkErase)             okNow = wel & ~bpAny;
  end

  always_comb begin
    strobe.setWel = live & cmdWren;
    strobe.clrWel = live & ~cmdWren;
    strobe.loadSr = live & cmdWrsr & okNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept <= 1'b0;
      reject <= 1'b0;
    end else begin
      accept <= live & okNow;
      reject <= live & ~okNow;
    end
  end
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int SECTOR_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdProg,
  input  logic              cmdSecErase,
  input  logic              cmdBulkErase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        srData,
  input  logic              wpLevel,
  input  logic              busy,
  output logic              accept,
  output logic              reject,
  output logic              hwMode,
  output logic [7:0]        statusOut
);
  wpgStrobe_t strobe;
  logic wel, hwLock, addrProt, bpAny;

  wpg_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdProg(cmdProg), .cmdSecErase(cmdSecErase), .cmdBulkErase(cmdBulkErase),
    .busy(busy), .wel(wel), .hwLock(hwLock), .addrProt(addrProt), .bpAny(bpAny),
    .strobe(strobe), .accept(accept), .reject(reject)
  );

  wpg_datapath #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srData(srData), .addr(addr),
    .wpLevel(wpLevel), .busy(busy), .wel(wel), .hwLock(hwLock),
    .addrProt(addrProt), .bpAny(bpAny), .statusOut(statusOut)
  );

  assign hwMode = hwLock;
endmodule

// File: rtl/flash_wp_guard_chk.sv
module flash_wp_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       cmdWrsr,
  input logic       cmdProg,
  input logic       cmdSecErase,
  input logic       cmdBulkErase,
  input logic       wpLevel,
  input logic       busy,
  input logic       accept,
  input logic       reject,
  input logic       hwMode,
  input logic [7:0] statusOut
);
  logic anyCmd;
  assign anyCmd = cmdWren | cmdWrdi | cmdWrsr | cmdProg | cmdSecErase | cmdBulkErase;

  // Input assumption: one strobe at a time.
  a_in_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdWren, cmdWrdi, cmdWrsr, cmdProg, cmdSecErase, cmdBulkErase}));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && reject));

  a_r11_pulse_has_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (anyCmd && !busy) |=> (accept || reject));

  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!accept && !reject && $stable(statusOut[7:1])));

  a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWren && !busy) |=> (accept && statusOut[1]));

  a_r5_hw_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !busy && statusOut[7] && !wpLevel) |=> (reject && $stable(statusOut[7:2])));

  a_r5_mode_flag: assert property (@(posedge clk) disable iff (!rstN)
    hwMode == (statusOut[7] && !wpLevel));

  a_r8_bulk_guard: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBulkErase && !busy && (statusOut[4:2] != 3'd0)) |=> reject);

  a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdWrsr || cmdProg || cmdSecErase || cmdBulkErase) && !busy) |=> !statusOut[1]);
endmodule

bind flash_wp_guard flash_wp_guard_chk u_chk (.*);

// File: tb/sim_flash_wp_guard.sv
`timescale 1ns/1ps
module sim_flash_wp_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdProg = 0, cmdSecErase = 0, cmdBulkErase = 0;
  logic [21:0] addr = '0;
  logic [7:0]  srData = '0;
  logic wpLevel = 1'b1;
  logic busy = 1'b0;
  logic accept, reject, hwMode;
  logic [7:0] statusOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  typedef enum int {C_WREN, C_WRDI, C_WRSR, C_PROG, C_SE, C_BE} cmd_e;

  always #10 clk = ~clk;

  flash_wp_guard u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issues one strobe; returns the pulse seen in the following cycle.
  task automatic issue(input cmd_e c, input logic [21:0] a, input logic [7:0] d,
                       output bit acc, output bit rej);
    @(negedge clk);
    addr = a; srData = d;
    cmdWren = (c == C_WREN); cmdWrdi = (c == C_WRDI); cmdWrsr = (c == C_WRSR);
    cmdProg = (c == C_PROG); cmdSecErase = (c == C_SE); cmdBulkErase = (c == C_BE);
    @(negedge clk);
    {cmdWren, cmdWrdi, cmdWrsr, cmdProg, cmdSecErase, cmdBulkErase} = '0;
    acc = accept; rej = reject;
  endtask

  task automatic doReset();
    wpLevel = 1'b1; busy = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic setStatus(input logic [7:0] d);
    bit a, r;
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, d, a, r);
  endtask

  task automatic t_reset();
    doReset();
    check(statusOut == 8'h00, "R1 status", statusOut, 0);
    check(!accept && !reject, "R1 pulses", {accept, reject}, 0);
    check(hwMode == 1'b0, "R1 mode", hwMode, 0);
  endtask

  task automatic t_latch();
    bit a, r;
    doReset();
    issue(C_WREN, '0, '0, a, r);
    check(a && !r && statusOut[1], "R2 wren", {a, r, statusOut[1]}, 3'b101);
    @(negedge clk);
    check(!accept && !reject, "R11 pulse width", {accept, reject}, 0);
    issue(C_WRDI, '0, '0, a, r);
    check(a && !statusOut[1], "R2 wrdi", {a, statusOut[1]}, 2'b10);
  endtask

  task automatic t_srUnlocked();
    bit a, r;
    doReset();
    wpLevel = 1'b0;
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, 8'h14, a, r);
    check(a && statusOut == 8'h14, "R3 write pin low", statusOut, 8'h14);
    check(!statusOut[1], "R9 latch after wrsr", statusOut[1], 0);
    wpLevel = 1'b1;
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, 8'h08, a, r);
    check(a && statusOut == 8'h08, "R3 write pin high", statusOut, 8'h08);
  endtask

  task automatic t_noLatch();
    bit a, r;
    doReset();
    issue(C_WRSR, '0, 8'h9C, a, r);
    check(r && !a && statusOut == 8'h00, "R4 wrsr no latch", statusOut, 0);
    issue(C_PROG, '0, '0, a, r);
    check(r && !a, "R4 prog no latch", a, 0);
    issue(C_BE, '0, '0, a, r);
    check(r && !a, "R4 bulk no latch", a, 0);
  endtask

  task automatic t_hwOrders();
    bit a, r;
    // Order 1: pin low first, then set the lock bit.
    doReset();
    wpLevel = 1'b0;
    setStatus(8'h80);
    #1 check(hwMode == 1'b1, "R6 enter pin first", hwMode, 1);
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, 8'h00, a, r);
    check(r && statusOut == 8'h80, "R5 hw reject", statusOut, 8'h80);
    check(!statusOut[1], "R9 latch after reject", statusOut[1], 0);
    // Order 2: lock bit set with the pin high, then pin low.
    doReset();
    setStatus(8'h84);
    check(hwMode == 1'b0, "R6 lock pin high", hwMode, 0);
    wpLevel = 1'b0;
    #1 check(hwMode == 1'b1, "R6 enter lock first", hwMode, 1);
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, 8'h00, a, r);
    check(r && statusOut == 8'h84, "R5 hw reject 2", statusOut, 8'h84);
    // Exit by pin high only.
    wpLevel = 1'b1;
    #1 check(hwMode == 1'b0, "R6 exit", hwMode, 0);
    issue(C_WREN, '0, '0, a, r);
    issue(C_WRSR, '0, 8'h00, a, r);
    check(a && statusOut == 8'h00, "R6 write after exit", statusOut, 0);
  endtask

  task automatic t_ranges();
    bit a, r;
    doReset();
    for (int bp = 1; bp <= 7; bp++) begin
      int guarded;
      int first;
      guarded = (bp == 7) ? 64 : (1 << (bp - 1));
      first = 64 - guarded;
      setStatus(8'(bp << 2));
      issue(C_WREN, '0, '0, a, r);
      issue(C_PROG, 22'(first << 16) | 22'h00ABC, '0, a, r);
      check(r && !a, "R7 prog first guarded", a, 0);
      issue(C_WREN, '0, '0, a, r);
      issue(C_SE, 22'(63 << 16), '0, a, r);
      check(r && !a, "R7 erase top sector", a, 0);
      if (first > 0) begin
        issue(C_WREN, '0, '0, a, r);
        issue(C_PROG, 22'(((first - 1) << 16) | 16'hFFFF), '0, a, r);
        check(a && !r, "R7 prog below range", a, 1);
        issue(C_WREN, '0, '0, a, r);
        issue(C_SE, 22'((first - 1) << 16), '0, a, r);
        check(a && !r, "R7 erase below range", a, 1);
        check(!statusOut[1], "R9 latch after erase", statusOut[1], 0);
      end
    end
    setStatus(8'h00);
    issue(C_WREN, '0, '0, a, r);
    issue(C_PROG, 22'h3FFFFF, '0, a, r);
    check(a, "R7 prog unguarded top", a, 1);
  endtask

  task automatic t_bulk();
    bit a, r;
    doReset();
    setStatus(8'h04);
    issue(C_WREN, '0, '0, a, r);
    issue(C_BE, '0, '0, a, r);
    check(r && !a, "R8 bulk guarded", a, 0);
    setStatus(8'h00);
    issue(C_WREN, '0, '0, a, r);
    issue(C_BE, '0, '0, a, r);
    check(a && !r, "R8 bulk open", a, 1);
    check(!statusOut[1], "R9 latch after bulk", statusOut[1], 0);
  endtask

  task automatic t_busy();
    bit a, r;
    doReset();
    issue(C_WREN, '0, '0, a, r);
    busy = 1'b1;
    issue(C_WRSR, '0, 8'h9C, a, r);
    check(!a && !r, "R10 no pulse", {a, r}, 0);
    check(statusOut == 8'h03, "R10 status held", statusOut, 8'h03);
    issue(C_WRDI, '0, '0, a, r);
    check(statusOut[1], "R10 wrdi ignored", statusOut[1], 1);
    busy = 1'b0;
    #1 check(statusOut == 8'h02, "R10 busy bit", statusOut, 8'h02);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_srUnlocked();
    t_noLatch();
    t_hwOrders();
    t_ranges();
    t_bulk();
    t_busy();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule